// File: doc/BRIEF.md
# Front-Side Bus Request Capture with Two-Subphase Parity Check

This block sits on the receive side of a shared front-side bus whose lines are all active low. When the request strobe is asserted, it collects the two subphases that follow on the shared lines. The first subphase carries the request address and the second carries transaction attribute information. The 5-bit request-type bundle is collected in both subphases.

Two sample-enable inputs stand in for the two source-synchronous address strobes. Each one is a single-cycle pulse in the 2x-rate clock domain and marks one strobe edge. Each strobe latches its own slice of the lines, so the two slices may arrive in different cycles.

Once both slices of both subphases are present, the block checks the two parity pins of each subphase. The pins cover one signal group in the first subphase and the other group in the second. The block then emits one registered result beat. The beat holds active-high address, attribute and type values and four parity error flags.

Top module: `fsb_req_capture`

## Requirements
- R1: After synchronous reset `out_valid` is low, every result output is zero, and the block is idle.
- R2: A low level of `ads_n` on a clock edge starts a capture. The first sample pulse of each strobe lane after that edge stores subphase-1 lines, and the second stores subphase-2 lines. `out_addr` is the bitwise inverse of the subphase-1 address lines, with bit 0 standing for address bit 3.
- R3: `out_info` is the inverse of the subphase-2 address lines. `out_rtype_sp1` and `out_rtype_sp2` are the inverse of the request-type lines in subphase 1 and subphase 2.
- R4: Lane 0 (`strobe_en[0]`) latches the request-type lines, both parity pins, `addr_n[13:0]` (address bits 16..3) and `addr_n[34:33]` (address bits 37..36). Lane 1 (`strobe_en[1]`) latches only `addr_n[32:14]` (address bits 35..17). Each lane takes its bits only on its own pulse.
- R5: A parity pin is correct when it is high for an even number of low covered lines and low for an odd number. With every covered line high and the pin high, no error is flagged.
- R6: In subphase 1, `apar_n[0]` covers `addr_n[34:21]` (address bits 37..24) and `apar_n[1]` covers `addr_n[20:0]` together with `rtype_n`. `perr_sp1[k]` is set when pin k is wrong.
- R7: In subphase 2 the coverage swaps. `apar_n[1]` covers `addr_n[34:21]` and `apar_n[0]` covers `addr_n[20:0]` together with `rtype_n`, reported on `perr_sp2`.
- R8: `out_valid` is a single-cycle pulse. It appears on the clock edge after the edge that stored the last missing subphase-2 slice.
- R9: An `ads_n` assertion before the result beat discards the partial capture and restarts at subphase 1. This includes assertion on the edge that would have completed it, in which case no beat is produced.
- R10: Sample pulses while idle, and further pulses on a lane that already holds both subphases, are ignored and never produce a result beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2x-rate sample clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Request strobe, active low |
| addr_n | input | 35 | Address/attribute lines, bits 37..3, active low |
| rtype_n | input | 5 | Request-type lines, active low |
| strobe_en | input | 2 | One-cycle sample pulse per strobe lane |
| apar_n | input | 2 | Parity pins, sampled with lane 0 |
| out_valid | output | 1 | Result beat strobe |
| out_addr | output | 35 | Subphase-1 address, active high |
| out_info | output | 35 | Subphase-2 attribute bits, active high |
| out_rtype_sp1 | output | 5 | Subphase-1 request type, active high |
| out_rtype_sp2 | output | 5 | Subphase-2 request type, active high |
| perr_sp1 | output | 2 | Subphase-1 parity error per pin |
| perr_sp2 | output | 2 | Subphase-2 parity error per pin |

## Verification
The assertions take for granted that each sample pulse lasts exactly one clock, and that the parity pins are valid whenever lane 0 samples. They also take for granted that lines and pins are stable during the cycle in which a pulse is sampled. The stimulus drives every input at the falling clock edge and holds each pulse for one full period. It drives parity pins only together with a lane-0 pulse. Corrupted parity is injected deliberately to exercise the error flags. Lane pulses are also staggered, repeated and issued while idle, to exercise the lane association and the rules for ignored pulses.

// File: rtl/fsb_req_pkg.sv
package fsb_req_pkg;
  // Line bundle widths
  localparam int ADDR_W = 35;   // address bits 37..3
  localparam int TYPE_W = 5;
  localparam int PAR_W  = 2;
  // Coverage split: index of address bit 24 within the bundle
  localparam int HI_LSB = 21;
  // Lane 0 owns the low and top address slices, lane 1 the middle
  localparam int LOW_W  = 14;   // address bits 16..3
  localparam int TOP_W  = 2;    // address bits 37..36
  localparam int MID_W  = ADDR_W - LOW_W - TOP_W;
  localparam int LANE0_W = TYPE_W + PAR_W + TOP_W + LOW_W;
  localparam int LANE1_W = MID_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr_n;
    logic [TYPE_W-1:0] type_n;
    logic [PAR_W-1:0]  par_n;
  } subphase_t;
endpackage

// File: rtl/strobe_lane.sv
module strobe_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         armed,
  input  logic         sample,
  input  logic [W-1:0] lines,
  output logic [W-1:0] first_q,
  output logic [W-1:0] second_q,
  output logic         full
);
  logic [1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 2'd0;
      first_q  <= '0;
      second_q <= '0;
    end else if (restart) begin
      phase <= 2'd0;
    end else if (armed && sample && phase != 2'd2) begin
      if (phase == 2'd0) first_q  <= lines;
      else               second_q <= lines;
      phase <= phase + 2'd1;
    end
  end

  assign full = (phase == 2'd2);

  p_phase_range_r10: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);

  p_first_sample_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && sample && !restart && phase == 2'd0)
      |=> (phase == 2'd1 && first_q == $past(lines)));

  p_full_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (full && !restart) |=> full);
endmodule

// File: rtl/par_cover.sv
module par_cover
  import fsb_req_pkg::*;
#(
  parameter bit SWAP = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_n,
  input  logic [TYPE_W-1:0] type_n,
  input  logic [PAR_W-1:0]  par_n,
  output logic [PAR_W-1:0]  err
);
  logic hi_want;
  logic lo_want;

  // Pin high for an even count of low lines
  assign hi_want = ~(^(~addr_n[ADDR_W-1:HI_LSB]));
  assign lo_want = ~(^(~{addr_n[HI_LSB-1:0], type_n}));

  generate
    if (SWAP) begin : g_sp2
      assign err = {par_n[1] != hi_want, par_n[0] != lo_want};
    end else begin : g_sp1
      assign err = {par_n[1] != lo_want, par_n[0] != hi_want};
    end
  endgenerate

  always_comb begin
    if (&addr_n && &type_n && &par_n)
      p_all_high_clean_r5: assert (err == '0);
  end
endmodule

// File: rtl/fsb_req_capture.sv
module fsb_req_capture
  import fsb_req_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ads_n,
  input  logic [ADDR_W-1:0] addr_n,
  input  logic [TYPE_W-1:0] rtype_n,
  input  logic [1:0]        strobe_en,
  input  logic [PAR_W-1:0]  apar_n,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] out_info,
  output logic [TYPE_W-1:0] out_rtype_sp1,
  output logic [TYPE_W-1:0] out_rtype_sp2,
  output logic [PAR_W-1:0]  perr_sp1,
  output logic [PAR_W-1:0]  perr_sp2
);
  localparam int TOP_LSB  = LOW_W;
  localparam int PAR_LSB  = LOW_W + TOP_W;
  localparam int TYPE_LSB = PAR_LSB + PAR_W;

  logic start, busy, done;
  logic [LANE0_W-1:0] l0_in, l0_sp1, l0_sp2;
  logic [LANE1_W-1:0] l1_sp1, l1_sp2;
  logic l0_full, l1_full;
  subphase_t sp1, sp2;
  logic [PAR_W-1:0] err1, err2;

  assign start = ~ads_n;
  assign l0_in = {rtype_n, apar_n, addr_n[ADDR_W-1 -: TOP_W], addr_n[LOW_W-1:0]};

  strobe_lane #(.W(LANE0_W)) u_lane0 (
    .clk(clk), .rst(rst), .restart(start), .armed(busy), .sample(strobe_en[0]),
    .lines(l0_in), .first_q(l0_sp1), .second_q(l0_sp2), .full(l0_full));

  strobe_lane #(.W(LANE1_W)) u_lane1 (
    .clk(clk), .rst(rst), .restart(start), .armed(busy), .sample(strobe_en[1]),
    .lines(addr_n[LOW_W +: MID_W]), .first_q(l1_sp1), .second_q(l1_sp2),
    .full(l1_full));

  // Reassemble each subphase from the two lanes
  always_comb begin
    sp1.addr_n = {l0_sp1[TOP_LSB +: TOP_W], l1_sp1, l0_sp1[LOW_W-1:0]};
    sp1.type_n = l0_sp1[TYPE_LSB +: TYPE_W];
    sp1.par_n  = l0_sp1[PAR_LSB +: PAR_W];
    sp2.addr_n = {l0_sp2[TOP_LSB +: TOP_W], l1_sp2, l0_sp2[LOW_W-1:0]};
    sp2.type_n = l0_sp2[TYPE_LSB +: TYPE_W];
    sp2.par_n  = l0_sp2[PAR_LSB +: PAR_W];
  end

  par_cover #(.SWAP(1'b0)) u_pc1 (
    .addr_n(sp1.addr_n), .type_n(sp1.type_n), .par_n(sp1.par_n), .err(err1));
  par_cover #(.SWAP(1'b1)) u_pc2 (
    .addr_n(sp2.addr_n), .type_n(sp2.type_n), .par_n(sp2.par_n), .err(err2));

  assign done = busy && l0_full && l1_full && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy          <= 1'b0;
      out_valid     <= 1'b0;
      out_addr      <= '0;
      out_info      <= '0;
      out_rtype_sp1 <= '0;
      out_rtype_sp2 <= '0;
      perr_sp1      <= '0;
      perr_sp2      <= '0;
    end else begin
      out_valid <= done;
      if (start)     busy <= 1'b1;
      else if (done) busy <= 1'b0;
      if (done) begin
        out_addr      <= ~sp1.addr_n;
        out_info      <= ~sp2.addr_n;
        out_rtype_sp1 <= ~sp1.type_n;
        out_rtype_sp2 <= ~sp2.type_n;
        perr_sp1      <= err1;
        perr_sp2      <= err2;
      end
    end
  end

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_valid_from_busy_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(busy));

  p_abort_no_beat_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> !out_valid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !out_valid);
endmodule

// File: tb/fsb_req_capture_test.sv
module fsb_req_capture_test;
  localparam int AW = 35;
  localparam int TW = 5;
  localparam logic [AW-1:0] G1_MASK = {2'b00, {19{1'b1}}, {14{1'b0}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ads_n = 1'b1;
  logic [AW-1:0] addr_n = '1;
  logic [TW-1:0] rtype_n = '1;
  logic [1:0] strobe_en = 2'b00;
  logic [1:0] apar_n = 2'b11;
  logic out_valid;
  logic [AW-1:0] out_addr, out_info;
  logic [TW-1:0] out_rtype_sp1, out_rtype_sp2;
  logic [1:0] perr_sp1, perr_sp2;

  int tests = 0;
  int fails = 0;
  int beats = 0;
  bit done_flag = 1'b0;
  logic [83:0] expq[$];
  logic [63:0] seed = 64'h1234_5678_9abc_def1;

  always #10 clk = ~clk;

  fsb_req_capture uut (
    .clk(clk), .rst(rst), .ads_n(ads_n), .addr_n(addr_n), .rtype_n(rtype_n),
    .strobe_en(strobe_en), .apar_n(apar_n), .out_valid(out_valid),
    .out_addr(out_addr), .out_info(out_info), .out_rtype_sp1(out_rtype_sp1),
    .out_rtype_sp2(out_rtype_sp2), .perr_sp1(perr_sp1), .perr_sp2(perr_sp2));

  task automatic check(input bit ok, input string tag,
                       input logic [83:0] act, input logic [83:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed;
  endfunction

  // Correct pin levels from logical (active-high) values
  function automatic logic [1:0] good_par(input logic [AW-1:0] a,
                                          input logic [TW-1:0] t, input bit swap);
    logic hi, lo;
    hi = ~(^a[34:21]);
    lo = ~(^{a[20:0], t});
    return swap ? {hi, lo} : {lo, hi};
  endfunction

  task automatic ads_pulse();
    @(negedge clk);
    ads_n = 1'b0;
    @(negedge clk);
    ads_n = 1'b1;
  endtask

  task automatic pulse(input logic [1:0] en, input logic [AW-1:0] a_n,
                       input logic [TW-1:0] t_n, input logic [1:0] p_n);
    @(negedge clk);
    strobe_en = en; addr_n = a_n; rtype_n = t_n; apar_n = p_n;
    @(negedge clk);
    strobe_en = 2'b00; addr_n = '1; rtype_n = '1; apar_n = 2'b11;
  endtask

  task automatic send_req(input logic [AW-1:0] a, input logic [AW-1:0] inf,
                          input logic [TW-1:0] t1, input logic [TW-1:0] t2,
                          input logic [1:0] f1, input logic [1:0] f2);
    ads_pulse();
    pulse(2'b11, ~a, ~t1, good_par(a, t1, 1'b0) ^ f1);
    expq.push_back({a, inf, t1, t2, f1, f2});
    pulse(2'b11, ~inf, ~t2, good_par(inf, t2, 1'b1) ^ f2);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      beats++;
      if (expq.size() == 0) begin
        check(1'b0, "R9/R10 unexpected result beat",
              {out_addr, out_info, out_rtype_sp1, out_rtype_sp2, perr_sp1, perr_sp2}, '0);
      end else begin
        logic [83:0] e, act;
        e = expq.pop_front();
        act = {out_addr, out_info, out_rtype_sp1, out_rtype_sp2, perr_sp1, perr_sp2};
        check(act == e, "R2/R3/R6/R7 result beat", act, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a, inf;
    logic [TW-1:0] t1, t2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", {83'd0, out_valid}, '0);
    check({out_addr, out_info, out_rtype_sp1, out_rtype_sp2, perr_sp1, perr_sp2} == '0,
          "R1 outputs cleared",
          {out_addr, out_info, out_rtype_sp1, out_rtype_sp2, perr_sp1, perr_sp2}, '0);

    // R10 idle pulses ignored (monitor flags any beat)
    pulse(2'b11, 35'h0_1234_5678, 5'h03, 2'b01);
    pulse(2'b01, 35'h7_0000_ffff, 5'h1c, 2'b10);
    repeat (3) @(negedge clk);
    check(beats == 0, "R10 no beat from idle pulses", 84'(beats), 84'd0);

    // R5 all lines high with pins high: clean
    ads_pulse();
    pulse(2'b11, '1, '1, 2'b11);
    expq.push_back({84'd0});
    pulse(2'b11, '1, '1, 2'b11);
    // R8 exact beat timing
    check(out_valid == 1'b0, "R8 no beat on completing edge", {83'd0, out_valid}, '0);
    @(negedge clk);
    check(out_valid == 1'b1, "R8 beat one edge later", {83'd0, out_valid}, 84'd1);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 single-cycle beat", {83'd0, out_valid}, '0);

    // R2/R3/R6/R7 several patterns, clean parity
    for (int i = 0; i < 6; i++) begin
      a = 35'(next_rand()); inf = 35'(next_rand());
      t1 = 5'(next_rand()); t2 = 5'(next_rand());
      send_req(a, inf, t1, t2, 2'b00, 2'b00);
      repeat (2) @(negedge clk);
    end
    // Coverage discriminators: single bits in each group
    send_req(35'h4_0000_0000, 35'h0_0000_0001, 5'h00, 5'h00, 2'b00, 2'b00);
    repeat (2) @(negedge clk);
    send_req(35'h0_0010_0000, 35'h0_0020_0000, 5'h10, 5'h01, 2'b00, 2'b00);
    repeat (2) @(negedge clk);

    // R6/R7 injected parity errors per pin and subphase
    send_req(35'h1_2345_6789, 35'h2_aaaa_5555, 5'h0a, 5'h15, 2'b01, 2'b00);
    repeat (2) @(negedge clk);
    send_req(35'h3_f0f0_0f0f, 35'h0_1111_2222, 5'h1f, 5'h00, 2'b10, 2'b00);
    repeat (2) @(negedge clk);
    send_req(35'h5_5555_5555, 35'h6_6666_6666, 5'h07, 5'h18, 2'b00, 2'b01);
    repeat (2) @(negedge clk);
    send_req(35'h0_dead_beef, 35'h7_cafe_f00d, 5'h11, 5'h0e, 2'b11, 2'b10);
    repeat (2) @(negedge clk);

    // R4 lanes sampled in separate cycles, other lines junk
    a = 35'h2_4681_3579; inf = 35'h5_1357_2468; t1 = 5'h09; t2 = 5'h16;
    ads_pulse();
    pulse(2'b01, ~a ^ (G1_MASK & 35'h7_ffff_ffff), ~t1, good_par(a, t1, 1'b0));
    @(negedge clk);
    pulse(2'b10, ~a ^ (~G1_MASK & 35'h5_a5a5_a5a5), ~t1 ^ 5'h1f,
          ~good_par(a, t1, 1'b0));
    expq.push_back({a, inf, t1, t2, 2'b00, 2'b00});
    pulse(2'b10, ~inf ^ (~G1_MASK), ~t2 ^ 5'h0f, 2'b00);
    pulse(2'b01, ~inf ^ G1_MASK, ~t2, good_par(inf, t2, 1'b1));
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R4 staggered lanes produced beat", 84'(expq.size()), '0);

    // R10 extra lane-1 pulse after it is full is ignored
    a = 35'h1_0f0f_1234; inf = 35'h3_3333_0001; t1 = 5'h02; t2 = 5'h1d;
    ads_pulse();
    pulse(2'b11, ~a, ~t1, good_par(a, t1, 1'b0));
    pulse(2'b10, ~inf, '1, 2'b11);
    pulse(2'b10, 35'h0_0000_0000, 5'h00, 2'b00);
    expq.push_back({a, inf, t1, t2, 2'b00, 2'b00});
    pulse(2'b01, ~inf, ~t2, good_par(inf, t2, 1'b1));
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R10 extra pulse ignored", 84'(expq.size()), '0);

    // R9 restart after partial capture
    ads_pulse();
    pulse(2'b11, 35'h0_0bad_0bad, 5'h13, 2'b00);
    send_req(35'h6_0123_4567, 35'h1_89ab_cdef, 5'h05, 5'h1a, 2'b00, 2'b00);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R9 restart gives one beat", 84'(expq.size()), '0);

    // R9 restart on the completing edge: no beat
    beats = 0;
    ads_pulse();
    pulse(2'b11, 35'h0, 5'h0, 2'b00);
    pulse(2'b11, 35'h0, 5'h0, 2'b00);
    ads_n = 1'b0;
    @(negedge clk);
    ads_n = 1'b1;
    check(out_valid == 1'b0, "R9 abort at completion", {83'd0, out_valid}, '0);
    repeat (3) @(negedge clk);
    check(beats == 0, "R9 aborted capture silent", 84'(beats), '0);
    send_req(35'h2_2222_2222, 35'h4_4444_4444, 5'h08, 5'h10, 2'b00, 2'b00);
    repeat (3) @(negedge clk);
    check(beats == 1 && expq.size() == 0, "R9 capture after abort", 84'(beats), 84'd1);

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule